// File: doc/BRIEF.md
# Standby Mode Sequencer

The block sequences a small controller core into and out of its standby states. Software sets a two-bit mode field in an 8-bit mode register. It can write the whole byte or change a single bit. It then raises a standby request while the separate stop-enable control is high. The block picks one of four standby states from the mode field and the sub-clock indication:

- a light idle that keeps the oscillator, flash and PLL running;
- a deeper idle that keeps only the main oscillator;
- a full stop;
- a sub-clock idle.

It drives the CPU-clock, main-oscillator, flash and PLL enables to match the chosen state.

An unmasked wake-up interrupt ends standby. The light idle returns to run at once. The deeper idle and the stop state first run a recovery wait of 2^(sel+WAIT_SHIFT) main-clock cycles, where sel is a 3-bit wait-select register. The sub-clock idle waits for 12 sub-clock ticks. A one-cycle resume pulse marks each return to run. A state code output shows where the sequencer is.

Top module: `standby_seq`

## Requirements
- R1: After reset the mode register reads 0x00, state_o is RUN (0), all four enables are 1 and resume_o is 0.
- R2: Only bits 1:0 of the mode register hold data. A byte write loads both bits, and bits 7:2 always read 0. A single-bit write to index 0 or 1 changes only that bit. A single-bit write to index 2..7 changes nothing. A byte write takes priority over a single-bit write in the same cycle.
- R3: A standby request taken in RUN with stop-enable high moves the state one cycle later. The target depends on the mode field and sub_mode_i:
  - 11 selects STOP (3) in either clock mode.
  - With sub_mode_i high, any other code selects SUB_IDLE (4).
  - With sub_mode_i low, 00 selects IDLE1 (1), 01 selects STOP (3) and 10 selects IDLE2 (2).
  - The WAIT state code is 5.
- R4: A standby request with stop-enable low leaves the state at RUN.
- R5: The enables, listed as {cpu, osc, flash, pll}, take these values in each state:

  | State | Enables |
  |---|---|
  | RUN | 1111 |
  | IDLE1 | 0111 |
  | IDLE2 | 0100 |
  | STOP | 0000 |
  | SUB_IDLE | 0000 |
  | WAIT after IDLE2 or STOP | 0111 |
  | WAIT after SUB_IDLE | 0000 |

- R6: A wake-up in IDLE1 returns to RUN on the next cycle without passing through WAIT.
- R7: A wake-up in IDLE2 or STOP enters WAIT. The block stays in WAIT for exactly 2^(sel+2) cycles, where sel is the last value written to the wait-select register (reset 0), and then returns to RUN.
- R8: A wake-up in SUB_IDLE enters WAIT. The block stays there until the 12th sub_tick_i pulse seen in WAIT, and returns to RUN on that pulse. Main-clock cycles without a tick do not advance the wait.
- R9: A wake-up during WAIT does not restart the wait. A wake-up in RUN has no effect. A standby request outside RUN has no effect.
- R10: resume_o is high for exactly the first cycle after each return to RUN, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_byte_we_i | input | 1 | Byte write strobe for the mode register |
| cfg_wdata_i | input | 8 | Byte write data |
| cfg_bit_we_i | input | 1 | Single-bit write strobe |
| cfg_bit_idx_i | input | 3 | Bit index for a single-bit write |
| cfg_bit_val_i | input | 1 | Value for a single-bit write |
| cfg_rdata_o | output | 8 | Mode register read value |
| wait_we_i | input | 1 | Write strobe for the wait-select register |
| wait_sel_i | input | 3 | Wait-select value |
| stop_en_i | input | 1 | Stop-enable control; standby requests are honoured only when high |
| standby_req_i | input | 1 | Standby request pulse |
| sub_mode_i | input | 1 | High while the system runs from the sub-clock |
| sub_tick_i | input | 1 | One pulse per sub-clock cycle |
| wake_i | input | 1 | Unmasked wake-up interrupt |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| main_osc_en_o | output | 1 | Main oscillator enable |
| flash_en_o | output | 1 | Flash enable |
| pll_en_o | output | 1 | PLL enable |
| state_o | output | 3 | Current state code |
| resume_o | output | 1 | One-cycle pulse on return to RUN |

## Verification
A table drives all eight pairs of mode code and sub_mode_i through entry and wake-up. This tells apart the two codes that both reach STOP from the three that become SUB_IDLE in sub-clock operation. Wait-select values 0, 3 and 7 separate a fixed wait length from the programmed power-of-two length. Sub-tick pulses given one by one, with a long tick-free gap, show that the sub-clock idle counts ticks rather than cycles. Extra wake-ups in mid-wait show that the wait is not restarted, and writes to bits 2..7 show that those bits do not store data.

// File: rtl/standby_pkg.sv
package standby_pkg;
  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_IDLE1    = 3'd1,
    ST_IDLE2    = 3'd2,
    ST_STOP     = 3'd3,
    ST_SUB_IDLE = 3'd4,
    ST_WAIT     = 3'd5
  } sb_state_e;

  typedef struct packed {
    logic cpu;
    logic osc;
    logic flash;
    logic pll;
  } gate_t;
endpackage

// File: rtl/sb_mode_reg.sv
module sb_mode_reg
  import standby_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int MODE_W = 2,
  localparam int IDX_W = $clog2(REG_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_we_i,
  input  logic [REG_W-1:0] byte_wdata_i,
  input  logic             bit_we_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             bit_val_i,
  input  logic             sub_mode_i,
  output logic [REG_W-1:0] rdata_o,
  output sb_state_e        target_o
);
  logic [MODE_W-1:0] mode_bits;
  logic              unused_hi;

  assign unused_hi = ^byte_wdata_i[REG_W-1:MODE_W];

  for (genvar g = 0; g < REG_W; g++) begin : g_bit
    if (g < MODE_W) begin : g_rw
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                      q <= 1'b0;
        else if (byte_we_i)                               q <= byte_wdata_i[g];
        else if (bit_we_i && bit_idx_i == IDX_W'(g))      q <= bit_val_i;
      end
      assign mode_bits[g] = q;
      assign rdata_o[g]   = q;
    end else begin : g_zero
      assign rdata_o[g] = 1'b0;
    end
  end

  // code 11 wins over sub-clock; other codes fold to sub-idle in sub-clock
  always_comb begin
    if (&mode_bits)       target_o = ST_STOP;
    else if (sub_mode_i)  target_o = ST_SUB_IDLE;
    else begin
      case (mode_bits)
        2'b00:   target_o = ST_IDLE1;
        2'b10:   target_o = ST_IDLE2;
        default: target_o = ST_STOP;
      endcase
    end
  end
endmodule

// File: rtl/sb_wait_timer.sv
module sb_wait_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sb_fsm.sv
module sb_fsm
  import standby_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             stop_en_i,
  input  sb_state_e        target_i,
  input  logic             wake_i,
  input  logic             sub_tick_i,
  input  logic [CNT_W-1:0] main_val_i,
  input  logic [CNT_W-1:0] sub_val_i,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             dec_o,
  output sb_state_e        state_o,
  output logic             sub_wait_o,
  output logic             resume_o
);
  sb_state_e state_q, state_d;
  logic      sub_wait_q, sub_wait_d;
  logic      resume_q, resume_d;

  assign dec_o = (state_q == ST_WAIT) && (sub_wait_q ? sub_tick_i : 1'b1);

  always_comb begin
    state_d    = state_q;
    sub_wait_d = sub_wait_q;
    resume_d   = 1'b0;
    load_o     = 1'b0;
    load_val_o = '0;
    case (state_q)
      ST_RUN: if (req_i && stop_en_i) state_d = target_i;
      ST_IDLE1: if (wake_i) begin
        state_d  = ST_RUN;
        resume_d = 1'b1;
      end
      ST_IDLE2, ST_STOP: if (wake_i) begin
        state_d    = ST_WAIT;
        load_o     = 1'b1;
        load_val_o = main_val_i;
        sub_wait_d = 1'b0;
      end
      ST_SUB_IDLE: if (wake_i) begin
        state_d    = ST_WAIT;
        load_o     = 1'b1;
        load_val_o = sub_val_i;
        sub_wait_d = 1'b1;
      end
      ST_WAIT: if (dec_o && zero_i) begin
        state_d  = ST_RUN;
        resume_d = 1'b1;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RUN;
      sub_wait_q <= 1'b0;
      resume_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      sub_wait_q <= sub_wait_d;
      resume_q   <= resume_d;
    end
  end

  assign state_o    = state_q;
  assign sub_wait_o = sub_wait_q;
  assign resume_o   = resume_q;
endmodule

// File: rtl/sb_gate_decode.sv
module sb_gate_decode
  import standby_pkg::*;
(
  input  sb_state_e state_i,
  input  logic      sub_wait_i,
  output gate_t     gate_o
);
  always_comb begin
    case (state_i)
      ST_RUN:   gate_o = '{cpu: 1'b1, osc: 1'b1, flash: 1'b1, pll: 1'b1};
      ST_IDLE1: gate_o = '{cpu: 1'b0, osc: 1'b1, flash: 1'b1, pll: 1'b1};
      ST_IDLE2: gate_o = '{cpu: 1'b0, osc: 1'b1, flash: 1'b0, pll: 1'b0};
      // main recovery restarts oscillator, flash and PLL; sub recovery keeps them off
      ST_WAIT:  gate_o = sub_wait_i ? '{cpu: 1'b0, osc: 1'b0, flash: 1'b0, pll: 1'b0}
                                    : '{cpu: 1'b0, osc: 1'b1, flash: 1'b1, pll: 1'b1};
      default:  gate_o = '{cpu: 1'b0, osc: 1'b0, flash: 1'b0, pll: 1'b0};
    endcase
  end
endmodule

// File: rtl/standby_seq.sv
module standby_seq
  import standby_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int MODE_W     = 2,
  parameter int SEL_W      = 3,
  parameter int WAIT_SHIFT = 2,
  parameter int SUB_CYCLES = 12,
  localparam int IDX_W     = $clog2(REG_W),
  localparam int MAIN_W    = (2 ** SEL_W) - 1 + WAIT_SHIFT + 1,
  localparam int SUB_W     = $clog2(SUB_CYCLES) + 1,
  localparam int CNT_W     = (MAIN_W > SUB_W) ? MAIN_W : SUB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_byte_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  input  logic             cfg_bit_we_i,
  input  logic [IDX_W-1:0] cfg_bit_idx_i,
  input  logic             cfg_bit_val_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  input  logic             wait_we_i,
  input  logic [SEL_W-1:0] wait_sel_i,
  input  logic             stop_en_i,
  input  logic             standby_req_i,
  input  logic             sub_mode_i,
  input  logic             sub_tick_i,
  input  logic             wake_i,
  output logic             cpu_clk_en_o,
  output logic             main_osc_en_o,
  output logic             flash_en_o,
  output logic             pll_en_o,
  output logic [2:0]       state_o,
  output logic             resume_o
);
  sb_state_e        target, state;
  logic [SEL_W-1:0] wait_sel_q;
  logic [CNT_W-1:0] main_val, sub_val, load_val;
  logic             load, dec, zero, sub_wait;
  gate_t            gate;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wait_sel_q <= '0;
    else if (wait_we_i) wait_sel_q <= wait_sel_i;
  end

  // down-counter is loaded with length-1 so the wait lasts exactly the length
  assign main_val = (CNT_W'(1) << (wait_sel_q + WAIT_SHIFT)) - CNT_W'(1);
  assign sub_val  = CNT_W'(SUB_CYCLES - 1);

  sb_mode_reg #(.REG_W(REG_W), .MODE_W(MODE_W)) u_mode (
    .clk_i, .rst_ni,
    .byte_we_i(cfg_byte_we_i), .byte_wdata_i(cfg_wdata_i),
    .bit_we_i(cfg_bit_we_i), .bit_idx_i(cfg_bit_idx_i), .bit_val_i(cfg_bit_val_i),
    .sub_mode_i, .rdata_o(cfg_rdata_o), .target_o(target)
  );

  sb_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni,
    .req_i(standby_req_i), .stop_en_i, .target_i(target), .wake_i, .sub_tick_i,
    .main_val_i(main_val), .sub_val_i(sub_val), .zero_i(zero),
    .load_o(load), .load_val_o(load_val), .dec_o(dec),
    .state_o(state), .sub_wait_o(sub_wait), .resume_o
  );

  sb_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val), .dec_i(dec), .zero_o(zero)
  );

  sb_gate_decode u_gate (.state_i(state), .sub_wait_i(sub_wait), .gate_o(gate));

  assign cpu_clk_en_o  = gate.cpu;
  assign main_osc_en_o = gate.osc;
  assign flash_en_o    = gate.flash;
  assign pll_en_o      = gate.pll;
  assign state_o       = state;
endmodule

// File: rtl/standby_seq_chk.sv
module standby_seq_chk
  import standby_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_byte_we_i,
  input logic       cfg_bit_we_i,
  input logic [2:0] cfg_bit_idx_i,
  input logic [7:0] cfg_rdata_o,
  input logic       stop_en_i,
  input logic       standby_req_i,
  input logic       cpu_clk_en_o,
  input logic       main_osc_en_o,
  input logic       flash_en_o,
  input logic       pll_en_o,
  input logic [2:0] state_o,
  input logic       resume_o
);
  p_hi_bit_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_bit_we_i && !cfg_byte_we_i && cfg_bit_idx_i >= 3'd2) |=> $stable(cfg_rdata_o));

  p_no_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_RUN && standby_req_i && !stop_en_i) |=> state_o == ST_RUN);

  p_idle2_gates_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE2) |-> (!cpu_clk_en_o && main_osc_en_o && !flash_en_o && !pll_en_o));

  p_idle1_exit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == ST_IDLE1 && state_o != ST_IDLE1) |-> state_o == ST_RUN);

  p_wait_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_WAIT && $past(state_o) != ST_WAIT) |->
      ($past(state_o) == ST_IDLE2 || $past(state_o) == ST_STOP || $past(state_o) == ST_SUB_IDLE));

  p_resume_edge_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> (state_o == ST_RUN && $past(state_o) != ST_RUN));

  p_resume_needed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_RUN && $past(state_o) != ST_RUN) |-> resume_o);
endmodule

bind standby_seq standby_seq_chk u_chk (
  .clk_i, .rst_ni, .cfg_byte_we_i, .cfg_bit_we_i, .cfg_bit_idx_i, .cfg_rdata_o,
  .stop_en_i, .standby_req_i, .cpu_clk_en_o, .main_osc_en_o, .flash_en_o, .pll_en_o,
  .state_o, .resume_o
);

// File: tb/sim_standby_seq.sv
module sim_standby_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 200000;

  // {sub_mode, mode[1:0], state[2:0], gates{cpu,osc,flash,pll}}
  localparam logic [9:0] VEC [8] = '{
    10'b0_00_001_0111, 10'b0_01_011_0000, 10'b0_10_010_0100, 10'b0_11_011_0000,
    10'b1_00_100_0000, 10'b1_01_100_0000, 10'b1_10_100_0000, 10'b1_11_011_0000
  };

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       cfg_byte_we_i = 0, cfg_bit_we_i = 0, cfg_bit_val_i = 0;
  logic [7:0] cfg_wdata_i = 0;
  logic [2:0] cfg_bit_idx_i = 0;
  logic [7:0] cfg_rdata_o;
  logic       wait_we_i = 0;
  logic [2:0] wait_sel_i = 0;
  logic       stop_en_i = 0, standby_req_i = 0, sub_mode_i = 0, sub_tick_i = 0, wake_i = 0;
  logic       cpu_clk_en_o, main_osc_en_o, flash_en_o, pll_en_o, resume_o;
  logic [2:0] state_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  standby_seq u0 (.*);

  function automatic logic [3:0] gates();
    return {cpu_clk_en_o, main_osc_en_o, flash_en_o, pll_en_o};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic wr_byte(input logic [7:0] v);
    cyc(); cfg_byte_we_i = 1; cfg_wdata_i = v;
    cyc(); cfg_byte_we_i = 0;
  endtask

  task automatic wr_bit(input logic [2:0] idx, input logic v);
    cyc(); cfg_bit_we_i = 1; cfg_bit_idx_i = idx; cfg_bit_val_i = v;
    cyc(); cfg_bit_we_i = 0;
  endtask

  task automatic wr_sel(input logic [2:0] v);
    cyc(); wait_we_i = 1; wait_sel_i = v;
    cyc(); wait_we_i = 0;
  endtask

  task automatic request();
    cyc(); standby_req_i = 1;
    cyc(); standby_req_i = 0;
  endtask

  task automatic wake();
    cyc(); wake_i = 1;
    cyc(); wake_i = 0;
  endtask

  task automatic tick();
    cyc(); sub_tick_i = 1;
    cyc(); sub_tick_i = 0;
  endtask

  // wake and hold ticks until RUN is reached again
  task automatic drain();
    sub_tick_i = 1;
    wake();
    sub_tick_i = 1;
    for (int i = 0; i < 2000 && state_o != 3'd0; i++) cyc();
    sub_tick_i = 0;
  endtask

  // counts WAIT cycles after a wake; optional extra wake at cycle 3
  task automatic measure_wait(input string tag, input int exp_n, input bit extra_wake);
    int n = 0;
    wake();
    while (state_o == 3'd5 && n < 5000) begin
      n++;
      if (extra_wake && n == 3) wake_i = 1;
      if (extra_wake && n == 4) wake_i = 0;
      cyc();
    end
    chk(tag, n, exp_n);
    chk({tag, " resume"}, resume_o, 1'b1);
    cyc();
    chk("R10 resume one cycle", resume_o, 1'b0);
  endtask

  initial begin
    repeat (3) cyc();
    // R1 reset state
    chk("R1 rdata", cfg_rdata_o, 8'h00);
    chk("R1 state", state_o, 3'd0);
    chk("R1 gates", gates(), 4'b1111);
    chk("R1 resume", resume_o, 1'b0);
    rst_ni = 1;
    cyc();

    // R3 R5 table walk over all mode codes and clock modes
    stop_en_i = 1;
    for (int i = 0; i < 8; i++) begin
      sub_mode_i = VEC[i][9];
      wr_byte({6'b0, VEC[i][8:7]});
      request();
      chk($sformatf("R3 entry vec%0d", i), state_o, VEC[i][6:4]);
      chk($sformatf("R5 gates vec%0d", i), gates(), VEC[i][3:0]);
      drain();
      chk($sformatf("R3 back to run vec%0d", i), state_o, 3'd0);
    end
    sub_mode_i = 0;

    // R2 register access
    wr_byte(8'hFF);  chk("R2 byte ff", cfg_rdata_o, 8'h03);
    wr_byte(8'hFC);  chk("R2 byte fc", cfg_rdata_o, 8'h00);
    wr_bit(3'd1, 1); chk("R2 bit1 set", cfg_rdata_o, 8'h02);
    wr_bit(3'd0, 1); chk("R2 bit0 set", cfg_rdata_o, 8'h03);
    wr_bit(3'd0, 0); chk("R2 bit0 clr", cfg_rdata_o, 8'h02);
    wr_bit(3'd5, 1); chk("R2 bit5 ignored", cfg_rdata_o, 8'h02);
    wr_bit(3'd2, 1); chk("R2 bit2 ignored", cfg_rdata_o, 8'h02);
    cyc(); cfg_byte_we_i = 1; cfg_wdata_i = 8'h01; cfg_bit_we_i = 1; cfg_bit_idx_i = 1; cfg_bit_val_i = 1;
    cyc(); cfg_byte_we_i = 0; cfg_bit_we_i = 0;
    chk("R2 byte over bit", cfg_rdata_o, 8'h01);

    // R4 stop-enable low blocks entry
    wr_byte(8'h02);
    stop_en_i = 0;
    request();
    chk("R4 state", state_o, 3'd0);
    chk("R4 gates", gates(), 4'b1111);
    stop_en_i = 1;

    // R9 wake in RUN ignored
    wake();
    chk("R9 wake in run state", state_o, 3'd0);
    chk("R9 wake in run resume", resume_o, 1'b0);

    // R6 idle1 exits straight to run
    wr_byte(8'h00);
    request();
    chk("R6 in idle1", state_o, 3'd1);
    wake();
    chk("R6 run after wake", state_o, 3'd0);
    chk("R6 resume", resume_o, 1'b1);
    cyc();
    chk("R10 resume drop", resume_o, 1'b0);

    // R7 programmed wait length, idle2 and stop
    wr_byte(8'h02);
    request();
    measure_wait("R7 idle2 sel0", 4, 0);
    wr_sel(3'd3);
    wr_byte(8'h01);
    request();
    chk("R7 stop entered", state_o, 3'd3);
    measure_wait("R7 stop sel3", 32, 0);
    wr_sel(3'd7);
    wr_byte(8'h03);
    request();
    measure_wait("R7 stop sel7", 512, 0);

    // R9 request outside RUN ignored, extra wake does not restart
    wr_sel(3'd1);
    wr_byte(8'h02);
    request();
    wr_byte(8'h00);
    request();
    chk("R9 request in idle2", state_o, 3'd2);
    chk("R5 wait gates pre", gates(), 4'b0100);
    measure_wait("R9 no restart", 8, 1);

    // R8 sub-idle counts ticks, not cycles
    sub_mode_i = 1;
    request();
    chk("R8 sub idle", state_o, 3'd4);
    wake();
    chk("R8 in wait", state_o, 3'd5);
    chk("R5 sub wait gates", gates(), 4'b0000);
    repeat (40) cyc();
    chk("R8 no tick no progress", state_o, 3'd5);
    for (int k = 0; k < 11; k++) tick();
    chk("R8 after 11 ticks", state_o, 3'd5);
    tick();
    chk("R8 after 12 ticks", state_o, 3'd0);
    chk("R10 sub resume", resume_o, 1'b1);
    sub_mode_i = 0;

    // R1 reset in the middle of standby
    wr_byte(8'h03);
    request();
    chk("R1 pre-reset stop", state_o, 3'd3);
    rst_ni = 0;
    cyc();
    chk("R1 mid reset state", state_o, 3'd0);
    chk("R1 mid reset rdata", cfg_rdata_o, 8'h00);
    chk("R1 mid reset gates", gates(), 4'b1111);
    rst_ni = 1;
    cyc();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule